// File: doc/BRIEF.md
# Motor Bridge Fault Guard

This block watches three digital comparator flags from the analog side of a motor bridge: supply undervoltage, output overcurrent and over-temperature. From them it produces one bridge-disable signal, one active-low fault flag meant to drive an open-drain pad, and one live status bit per fault source. The comparator flags are first passed through a configurable synchronizer. Any hysteresis on the undervoltage and temperature thresholds is applied upstream.

The overcurrent and level-type faults recover in different ways. An overcurrent flag counts as a fault only after it has stayed high for a deglitch window. The bridge is then locked off for a fixed retry window. After that the bridge is released to follow its commands again. If the overcurrent is still there, the same deglitch-and-retry cycle runs again. Undervoltage and over-temperature keep the bridge off for exactly as long as their flags stay high. Undervoltage also holds the overcurrent counters in reset.

Top module: `fault_guard`

## Requirements
- R1: The overcurrent flag must be high for `DEGLITCH_CYC` consecutive synchronized cycles before an overcurrent lock starts. A shorter pulse leaves every output unchanged and restarts the count.
- R2: An overcurrent lock holds `bridge_off_o` high, `stat_oc_o` high and `fault_n_o` low for exactly `RETRY_CYC` cycles. After that the lock releases on its own, whatever the flag is doing.
- R3: If the overcurrent flag is still high when a lock releases, a new lock starts `DEGLITCH_CYC` cycles later. The cycle repeats for as long as the flag stays high.
- R4: While the synchronized undervoltage flag is high, the deglitch and retry counters are held in reset. A lock already running ends on the next cycle, and the overcurrent flag has no effect. Counting starts from zero once the flag clears.
- R5: `bridge_off_o` and `stat_uv_o` are high in every cycle in which the synchronized undervoltage flag is high. Both clear in the same cycle the flag clears, when no other fault is active.
- R6: `bridge_off_o` and `stat_ot_o` are high in every cycle in which the synchronized over-temperature flag is high. Both clear in the same cycle the flag clears, when no other fault is active.
- R7: `fault_n_o` is 0 exactly when any status bit is 1, and `bridge_off_o` is its complement. The status bits are not sticky and show only the faults active in that cycle.
- R8: Each fault flag reaches the outputs through `SYNC_STAGES` register stages. A change driven before clock edge k is visible after edge k+`SYNC_STAGES`-1. With 0 stages, the flags act directly.
- R9: During and right after reset, all status bits are 0, `bridge_off_o` is 0 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_flag_i | input | 1 | Supply undervoltage comparator flag, active high |
| oc_flag_i | input | 1 | Output overcurrent comparator flag, active high |
| ot_flag_i | input | 1 | Over-temperature comparator flag, active high |
| bridge_off_o | output | 1 | Forces all bridge switches off while high |
| fault_n_o | output | 1 | Fault flag, low while any fault is active (open-drain pull-down control) |
| stat_uv_o | output | 1 | Undervoltage currently active |
| stat_oc_o | output | 1 | Overcurrent lock currently active |
| stat_ot_o | output | 1 | Over-temperature currently active |

## Verification
The assertions assume the comparator flags are ordinary digital levels that change only between clock edges. They also assume the upstream logic has already removed chatter from the undervoltage and temperature flags, so these flags carry no glitch filtering of their own. The bench drives every flag on the falling clock edge and holds it for whole cycles. It sweeps overcurrent pulse widths from one cycle up to past the deglitch window, and it combines faults only in the orders the requirements name, so every expected output follows from counting edges.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic {
      OCP_WATCH = 1'b0,
      OCP_LOCK  = 1'b1
   } ocp_state_t;

   typedef struct packed {
      logic uv;
      logic oc;
      logic ot;
   } fault_vec_t;

   localparam int unsigned FAULT_SRC_N = 3;

endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("fg_sync: WIDTH must be at least 1");
   end
   if (STAGES > 8) begin : g_bad_stages
      $error("fg_sync: STAGES above 8 is not supported");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] pipe_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pipe_q <= '0;
         end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) begin
               pipe_q[s] <= pipe_q[s-1];
            end
         end
      end

      assign q_o = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/fg_ocp_seq.sv
module fg_ocp_seq
   import fg_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 100,
   parameter int unsigned RETRY_CYC    = 150000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic oc_i,
   input  logic hold_i,
   output logic lock_o
);

   localparam int unsigned DG_W   = $clog2(DEGLITCH_CYC + 1);
   localparam int unsigned RT_W   = $clog2(RETRY_CYC + 1);
   localparam logic [DG_W-1:0] DG_LAST = DG_W'(DEGLITCH_CYC - 1);
   localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_CYC - 1);

   if (DEGLITCH_CYC < 1) begin : g_bad_dg
      $error("fg_ocp_seq: DEGLITCH_CYC must be at least 1");
   end
   if (RETRY_CYC < 1) begin : g_bad_rt
      $error("fg_ocp_seq: RETRY_CYC must be at least 1");
   end

   ocp_state_t      state_q;
   logic [DG_W-1:0] dg_q;
   logic [RT_W-1:0] rt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= OCP_WATCH;
         dg_q    <= '0;
         rt_q    <= '0;
      end else if (hold_i) begin
         state_q <= OCP_WATCH;
         dg_q    <= '0;
         rt_q    <= '0;
      end else begin
         unique case (state_q)
            OCP_WATCH: begin
               if (!oc_i) begin
                  dg_q <= '0;
               end else if (dg_q == DG_LAST) begin
                  state_q <= OCP_LOCK;
                  dg_q    <= '0;
                  rt_q    <= '0;
               end else begin
                  dg_q <= dg_q + 1'b1;
               end
            end
            OCP_LOCK: begin
               if (rt_q == RT_LAST) begin
                  state_q <= OCP_WATCH;
                  rt_q    <= '0;
                  dg_q    <= '0;
               end else begin
                  rt_q <= rt_q + 1'b1;
               end
            end
            default: state_q <= OCP_WATCH;
         endcase
      end
   end

   assign lock_o = (state_q == OCP_LOCK);

   // R1: a lock only begins after an overcurrent sample with no hold
   a_r1_lock_needs_oc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o) |-> ($past(oc_i) && !$past(hold_i)));

   // R1: the deglitch count never passes its window
   a_r1_dg_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dg_q < DG_W'(DEGLITCH_CYC));

   // R2: without a hold, a lock ends only when the retry window is complete
   a_r2_full_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(lock_o) && !$past(hold_i)) |-> ($past(rt_q) == RT_LAST));

   // R4: a hold clears the lock by the next cycle
   a_r4_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> !lock_o);

endmodule

// File: rtl/fault_guard.sv
module fault_guard
   import fg_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 100,
   parameter int unsigned RETRY_CYC    = 150000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic uv_flag_i,
   input  logic oc_flag_i,
   input  logic ot_flag_i,
   output logic bridge_off_o,
   output logic fault_n_o,
   output logic stat_uv_o,
   output logic stat_oc_o,
   output logic stat_ot_o
);

   fault_vec_t raw_flags;
   fault_vec_t sync_flags;
   fault_vec_t active;
   logic       oc_lock;

   assign raw_flags = '{uv: uv_flag_i, oc: oc_flag_i, ot: ot_flag_i};

   fg_sync #(
      .WIDTH  (FAULT_SRC_N),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_flags),
      .q_o    (sync_flags)
   );

   fg_ocp_seq #(
      .DEGLITCH_CYC (DEGLITCH_CYC),
      .RETRY_CYC    (RETRY_CYC)
   ) u_ocp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .oc_i   (sync_flags.oc),
      .hold_i (sync_flags.uv),
      .lock_o (oc_lock)
   );

   assign active = '{uv: sync_flags.uv, oc: oc_lock, ot: sync_flags.ot};

   assign stat_uv_o    = active.uv;
   assign stat_oc_o    = active.oc;
   assign stat_ot_o    = active.ot;
   assign bridge_off_o = |active;
   assign fault_n_o    = ~(|active);

   // R5: synchronized undervoltage always forces the bridge off
   a_r5_uv_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_flags.uv |-> bridge_off_o);

   // R6: synchronized over-temperature always forces the bridge off
   a_r6_ot_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_flags.ot |-> bridge_off_o);

   // R4: an overcurrent lock never coexists with a held undervoltage
   a_r4_uv_over_oc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_flags.uv && $past(sync_flags.uv)) |-> !stat_oc_o);

endmodule

// File: tb/fault_guard_bench.sv
module fault_guard_bench;

   localparam int unsigned D = 4;
   localparam int unsigned R = 10;
   localparam int unsigned S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0, oc = 1'b0, ot = 1'b0;
   logic bridge_off, fault_n, st_uv, st_oc, st_ot;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   fault_guard #(
      .DEGLITCH_CYC (D),
      .RETRY_CYC    (R),
      .SYNC_STAGES  (S)
   ) u_fault_guard (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .uv_flag_i    (uv),
      .oc_flag_i    (oc),
      .ot_flag_i    (ot),
      .bridge_off_o (bridge_off),
      .fault_n_o    (fault_n),
      .stat_uv_o    (st_uv),
      .stat_oc_o    (st_oc),
      .stat_ot_o    (st_ot)
   );

   function automatic logic [4:0] expv(input logic u, input logic o, input logic t);
      logic any;
      any = u | o | t;
      return {any, ~any, u, o, t};
   endfunction

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [4:0] exp_v);
      logic [4:0] act;
      act = {bridge_off, fault_n, st_uv, st_oc, st_ot};
      n_tests++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: {off,fault_n,uv,oc,ot} actual=%b expected=%b at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp_b);
      n_tests++;
      if (act !== exp_b) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp_b, $time);
      end
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      chk("R9 in reset", expv(0, 0, 0));
      rst_n = 1'b1;
      step(2);
      chk("R9 after reset", expv(0, 0, 0));

      // R5 / R8: undervoltage level fault with synchronizer latency
      uv = 1'b1;
      step(1); chk("R8 uv latency", expv(0, 0, 0));
      step(1); chk("R5 uv active", expv(1, 0, 0));
      step(5); chk("R5 uv held", expv(1, 0, 0));
      uv = 1'b0;
      step(1); chk("R8 uv release latency", expv(1, 0, 0));
      step(1); chk("R5 uv cleared", expv(0, 0, 0));

      // R6: over-temperature level fault
      ot = 1'b1;
      step(1); chk("R8 ot latency", expv(0, 0, 0));
      step(1); chk("R6 ot active", expv(0, 0, 1));
      step(7); chk("R6 ot held", expv(0, 0, 1));
      ot = 1'b0;
      step(2); chk("R6 ot cleared", expv(0, 0, 0));

      // R1: pulse-width sweep around the deglitch window
      for (int w = 1; w <= int'(D) + 2; w++) begin
         bit seen;
         seen = 1'b0;
         oc = 1'b1;
         for (int i = 0; i < w; i++) begin
            step(1);
            seen |= bridge_off;
         end
         oc = 1'b0;
         for (int i = 0; i < int'(S + D) + 2; i++) begin
            step(1);
            seen |= bridge_off;
         end
         chk_bit($sformatf("R1 pulse width %0d lock", w), seen, (w >= int'(D)));
         step(R + 2);
         chk($sformatf("R1 idle after width %0d", w), expv(0, 0, 0));
      end

      // R2: exact lock start and retry length
      oc = 1'b1;
      step(S + D - 1); chk("R1 one cycle before lock", expv(0, 0, 0));
      step(1);         chk("R2 lock starts", expv(0, 1, 0));
      oc = 1'b0;
      step(R - 1);     chk("R2 last lock cycle", expv(0, 1, 0));
      step(1);         chk("R2 lock released", expv(0, 0, 0));
      step(4);

      // R3: persistent overcurrent repeats the cycle
      oc = 1'b1;
      step(S + D);     chk("R3 first lock", expv(0, 1, 0));
      step(R);         chk("R3 released while oc high", expv(0, 0, 0));
      step(D - 1);     chk("R3 deglitch rerun", expv(0, 0, 0));
      step(1);         chk("R3 second lock", expv(0, 1, 0));
      oc = 1'b0;
      step(R);         chk("R3 end", expv(0, 0, 0));
      step(4);

      // R4: undervoltage overrides an overcurrent lock
      oc = 1'b1;
      step(S + D);     chk("R4 lock before uv", expv(0, 1, 0));
      uv = 1'b1;
      step(2);         chk("R4 uv arrives during lock", expv(1, 1, 0));
      step(1);         chk("R4 lock cleared by uv", expv(1, 0, 0));
      step(20);        chk("R4 oc ignored under uv", expv(1, 0, 0));
      uv = 1'b0;
      step(2);         chk("R4 uv gone, counters restart", expv(0, 0, 0));
      step(D - 1);     chk("R4 deglitch from zero", expv(0, 0, 0));
      step(1);         chk("R4 lock after full deglitch", expv(0, 1, 0));
      oc = 1'b0;
      step(R);         chk("R4 end", expv(0, 0, 0));

      // R7: combined faults, non-sticky status bits
      uv = 1'b1; ot = 1'b1;
      step(2);         chk("R7 uv and ot", expv(1, 0, 1));
      ot = 1'b0;
      step(2);         chk("R7 ot drops, uv stays", expv(1, 0, 0));
      uv = 1'b0;
      step(2);         chk("R7 all clear", expv(0, 0, 0));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule